// File: doc/BRIEF.md
# DS3 Far-End Block Error Transmit Code Generator

This block decides the three-bit far-end block error (FEBE) code that a C-bit parity DS3 transmitter places in the three C-bit slots of M-subframe 4. It watches the local receiver. Any framing-bit error, multiframe-bit error or C-bit parity error, and any cycle spent out of frame, marks the received M-frame as errored. The result of the most recently completed received M-frame is sent in the next transmitted M-frame. An errored frame is sent as `000`, the active code. A clean frame is sent as `111`, the null code.

Software can take over from the automatic path with a defeat bit. Once automatic insertion is defeated, a force bit picks either the active code or the null code for every frame. FEBE signalling has no meaning in E3 operation or in the M23 DS3 format. In either case the block drops its insert enable and parks the code at `111`.

The code output and the insert enable are registered. They are updated only on a transmit M-frame start strobe, so each transmitted frame carries one coherent code. The surrounding framer builds the DS3 frame itself and owns both frame strobes.

Top module: `febe_txgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `febe_code` = `111` and `febe_insert` = 0.
- R2: With automatic insertion enabled and the format C-bit parity DS3, a received M-frame is errored if any of these occurs in any of its cycles: a pulse on `rx_fbit_err`, a pulse on `rx_mbit_err`, a pulse on `rx_cp_err`, or `rx_oof` high. An errored frame is sent as code `000`.
- R3: With automatic insertion enabled, a received M-frame with none of the events of R2 is sent as code `111`.
- R4: An event in the same cycle as `rx_mframe_end` belongs to the frame that ends in that cycle. The accumulation clears at every `rx_mframe_end`, so the next frame starts clean.
- R5: The outputs change only in the cycle after a cycle with `tx_mframe_start` high. At all other times they hold their values.
- R6: When `rx_mframe_end` and `tx_mframe_start` are high in the same cycle, the transmitted code uses the result of the frame that ends in that cycle.
- R7: When several received frames complete between two transmit starts, only the latest completed frame decides the code.
- R8: With `cfg_auto_defeat` = 1, `cfg_force_active` = 0 gives code `111` and `cfg_force_active` = 1 gives code `000`, whatever errors were received.
- R9: With `cfg_auto_defeat` = 0, `cfg_force_active` has no effect on the code.
- R10: With `cfg_e3_mode` = 1 or `cfg_m23_fmt` = 1 at a transmit start, the block outputs `febe_insert` = 0 and `febe_code` = `111`, whatever the other settings. Otherwise it outputs `febe_insert` = 1.
- R11: The configuration inputs are sampled only in a cycle with `tx_mframe_start` high. A change between transmit starts does not alter the outputs.
- R12: `febe_code` only ever takes the value `000` or `111`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_fbit_err | input | 1 | One-cycle pulse per received framing-bit error |
| rx_mbit_err | input | 1 | One-cycle pulse per received multiframe-bit error |
| rx_cp_err | input | 1 | One-cycle pulse per received C-bit parity error |
| rx_oof | input | 1 | Receiver out-of-frame level |
| rx_mframe_end | input | 1 | High in the last cycle of a received M-frame |
| tx_mframe_start | input | 1 | High for one cycle when the transmitter begins an M-frame |
| cfg_auto_defeat | input | 1 | 1 = code set by `cfg_force_active`; 0 = automatic |
| cfg_force_active | input | 1 | Under defeat: 1 = send `000`, 0 = send `111` |
| cfg_e3_mode | input | 1 | 1 = E3 operation, FEBE not used |
| cfg_m23_fmt | input | 1 | 1 = M23 DS3 format, FEBE not used |
| febe_code | output | 3 | Code for the M-subframe 4 C-bit slots |
| febe_insert | output | 1 | 1 = the framer inserts `febe_code` |

## Verification
Two things can fall in the same cycle: the end of a received frame and the start of a transmitted frame. Sometimes an error event lands in that same cycle as well. The bench drives `rx_mframe_end` and `tx_mframe_start` together, once with an error pulse in that cycle and once with a clean frame ending over an errored predecessor. The scoreboard expects the code of the frame that has just ended, not the stale result held before. A second case places an error pulse on the frame-end cycle alone, and the bench expects it to count for the ending frame and leave the next frame clean.

// File: rtl/febe_pkg.sv
// Package: shared constants and types for the FEBE transmit code generator.
// Assumes the FEBE field is a repeated single bit (all zeros or all ones).
package febe_pkg;

    localparam int FEBE_W = 3;

    localparam logic [FEBE_W-1:0] FEBE_NULL   = '1;
    localparam logic [FEBE_W-1:0] FEBE_ACTIVE = '0;

    // Number of pulsed receive error sources (F bit, M bit, CP parity).
    localparam int ERR_SRC_N = 3;

    // Which path decided the code of a transmitted frame.
    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_AUTO   = 2'd1,
        SRC_MANUAL = 2'd2
    } febe_src_e;

    // Configuration sampled at a transmit frame boundary.
    typedef struct packed {
        logic auto_defeat;
        logic force_active;
        logic e3_mode;
        logic m23_fmt;
    } febe_cfg_t;

    // Replicate one decision bit across the code field (1 = active).
    function automatic logic [FEBE_W-1:0] febe_encode(input logic active);
        return active ? FEBE_ACTIVE : FEBE_NULL;
    endfunction

endpackage

// File: rtl/febe_err_accum.sv
// Module: febe_err_accum
// Collects receive error events over one received M-frame and keeps the
// verdict of the latest completed frame. Also offers a forwarded verdict
// for the case where the frame ends in the current cycle.
// Assumes: err_pulse bits are single-cycle pulses, oof is a level,
// frame_end is high for exactly the last cycle of a received frame.
module febe_err_accum #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_pulse,
    input  logic               oof,
    input  logic               frame_end,
    output logic               frame_err_q,
    output logic               frame_err_now
);

    logic acc_q;
    logic event_now;
    logic closing_verdict;

    // Any error source or out-of-frame in this cycle.
    assign event_now       = (|err_pulse) | oof;
    assign closing_verdict = acc_q | event_now;

    // Accumulate events within the current received frame; clear at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else if (frame_end) begin
            acc_q <= 1'b0;
        end else if (event_now) begin
            acc_q <= 1'b1;
        end
    end

    // Keep the verdict of the most recently completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_err_q <= 1'b0;
        end else if (frame_end) begin
            frame_err_q <= closing_verdict;
        end
    end

    // Forward the verdict of a frame that closes in this very cycle.
    assign frame_err_now = frame_end ? closing_verdict : frame_err_q;

    // R2: an event inside a frame marks the running accumulation.
    a_r2_event_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (event_now && !frame_end) |=> acc_q);

    // R4: the accumulation starts clean after every frame end.
    a_r4_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !acc_q);

    // R4: an event on the frame-end cycle counts for the ending frame.
    a_r4_last_cycle_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && event_now) |=> frame_err_q);

    // R7: a clean frame overwrites an earlier errored verdict.
    a_r7_latest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !acc_q && !event_now) |=> !frame_err_q);

endmodule

// File: rtl/febe_code_sel.sv
// Module: febe_code_sel
// Chooses the FEBE code and insert enable from the sampled configuration
// and the received-frame verdict. Purely combinational.
// Assumes the caller registers the result at a transmit frame boundary.
module febe_code_sel
    import febe_pkg::*;
(
    input  febe_cfg_t          cfg,
    input  logic               frame_err,
    output logic [FEBE_W-1:0]  code,
    output logic               insert,
    output febe_src_e          src
);

    // Priority: format disable, then manual override, then automatic.
    always_comb begin
        if (cfg.e3_mode || cfg.m23_fmt) begin
            src = SRC_OFF;
        end else if (cfg.auto_defeat) begin
            src = SRC_MANUAL;
        end else begin
            src = SRC_AUTO;
        end
    end

    // Map the chosen source to the code field and enable.
    always_comb begin
        unique case (src)
            SRC_MANUAL: begin
                code   = febe_encode(cfg.force_active);
                insert = 1'b1;
            end
            SRC_AUTO: begin
                code   = febe_encode(frame_err);
                insert = 1'b1;
            end
            default: begin
                code   = FEBE_NULL;
                insert = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/febe_out_reg.sv
// Module: febe_out_reg
// Output register for the code and insert enable, loaded only on a
// transmit frame boundary so no frame carries a mixed code.
// Assumes load is a single-cycle strobe.
module febe_out_reg #(
    parameter int              W        = 3,
    parameter logic [W-1:0]    RST_CODE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] code_d,
    input  logic         insert_d,
    output logic [W-1:0] code_q,
    output logic         insert_q
);

    // Capture the next frame's code at the boundary; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= RST_CODE;
            insert_q <= 1'b0;
        end else if (load) begin
            code_q   <= code_d;
            insert_q <= insert_d;
        end
    end

    // R5: outputs move only after a load strobe.
    a_r5_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(code_q) && $stable(insert_q)));

endmodule

// File: rtl/febe_txgen.sv
// Module: febe_txgen (top)
// Produces the far-end block error code for the M-subframe 4 C-bit slots
// of each transmitted C-bit parity DS3 M-frame, from receive-side error
// indications or from a software override.
// Assumes: both frame strobes come from the surrounding framer and are one
// cycle wide; configuration inputs are quasi-static register bits.
module febe_txgen
    import febe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_fbit_err,
    input  logic              rx_mbit_err,
    input  logic              rx_cp_err,
    input  logic              rx_oof,
    input  logic              rx_mframe_end,
    input  logic              tx_mframe_start,
    input  logic              cfg_auto_defeat,
    input  logic              cfg_force_active,
    input  logic              cfg_e3_mode,
    input  logic              cfg_m23_fmt,
    output logic [FEBE_W-1:0] febe_code,
    output logic              febe_insert
);

    logic [ERR_SRC_N-1:0] err_vec;
    logic                 frame_err_q;
    logic                 frame_err_now;
    febe_cfg_t            cfg_now;
    logic [FEBE_W-1:0]    next_code;
    logic                 next_insert;
    febe_src_e            next_src;

    // Gather pulsed error sources into one vector.
    assign err_vec = {rx_cp_err, rx_mbit_err, rx_fbit_err};

    // Present configuration; only used when the output register loads.
    assign cfg_now = '{auto_defeat:  cfg_auto_defeat,
                       force_active: cfg_force_active,
                       e3_mode:      cfg_e3_mode,
                       m23_fmt:      cfg_m23_fmt};

    febe_err_accum #(
        .NUM_SRC (ERR_SRC_N)
    ) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_pulse     (err_vec),
        .oof           (rx_oof),
        .frame_end     (rx_mframe_end),
        .frame_err_q   (frame_err_q),
        .frame_err_now (frame_err_now)
    );

    febe_code_sel u_sel (
        .cfg       (cfg_now),
        .frame_err (frame_err_now),
        .code      (next_code),
        .insert    (next_insert),
        .src       (next_src)
    );

    febe_out_reg #(
        .W        (FEBE_W),
        .RST_CODE (FEBE_NULL)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_mframe_start),
        .code_d   (next_code),
        .insert_d (next_insert),
        .code_q   (febe_code),
        .insert_q (febe_insert)
    );

    // R10: a disabled code always rests at the null value.
    a_r10_null_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !febe_insert |-> (febe_code == FEBE_NULL));

    // R10: E3 or M23 at a boundary removes insertion.
    a_r10_off_formats: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mframe_start && (cfg_e3_mode || cfg_m23_fmt)) |=> !febe_insert);

    // R12: only the two legal code values appear.
    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (febe_code == FEBE_NULL) || (febe_code == FEBE_ACTIVE));

    // R8: under defeat the force bit alone decides the code.
    a_r8_manual_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mframe_start && cfg_auto_defeat && !cfg_e3_mode && !cfg_m23_fmt)
        |=> (febe_code == ($past(cfg_force_active) ? FEBE_ACTIVE : FEBE_NULL)));

    // R6: a frame closing with an error at a transmit start is signalled at once.
    a_r6_same_cycle_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mframe_start && rx_mframe_end && (rx_fbit_err || rx_mbit_err || rx_cp_err || rx_oof)
         && !cfg_auto_defeat && !cfg_e3_mode && !cfg_m23_fmt)
        |=> (febe_code == FEBE_ACTIVE));

endmodule

// File: tb/febe_txgen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push the expected output of each
// transmitted frame; a monitor pops and compares after each frame start,
// and checks that the outputs hold in every other cycle.
module febe_txgen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_fbit_err = 1'b0;
    logic       rx_mbit_err = 1'b0;
    logic       rx_cp_err = 1'b0;
    logic       rx_oof = 1'b0;
    logic       rx_mframe_end = 1'b0;
    logic       tx_mframe_start = 1'b0;
    logic       cfg_auto_defeat = 1'b0;
    logic       cfg_force_active = 1'b0;
    logic       cfg_e3_mode = 1'b0;
    logic       cfg_m23_fmt = 1'b0;
    logic [2:0] febe_code;
    logic       febe_insert;

    // Expected {code, insert}
    localparam logic [3:0] E_ACT  = 4'b0001;
    localparam logic [3:0] E_NULL = 4'b1111;
    localparam logic [3:0] E_OFF  = 4'b1110;

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [3:0] q_val[$];
    string      q_req[$];
    logic [3:0] cur_exp = E_OFF;
    string      cur_req;
    logic       pend = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    febe_txgen uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_fbit_err      (rx_fbit_err),
        .rx_mbit_err      (rx_mbit_err),
        .rx_cp_err        (rx_cp_err),
        .rx_oof           (rx_oof),
        .rx_mframe_end    (rx_mframe_end),
        .tx_mframe_start  (tx_mframe_start),
        .cfg_auto_defeat  (cfg_auto_defeat),
        .cfg_force_active (cfg_force_active),
        .cfg_e3_mode      (cfg_e3_mode),
        .cfg_m23_fmt      (cfg_m23_fmt),
        .febe_code        (febe_code),
        .febe_insert      (febe_insert)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got code=%b insert=%b, expected code=%b insert=%b",
                     req, act[3:1], act[0], exp[3:1], exp[0]);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare popped expectations after each frame start, else hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                if (q_val.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R5: frame start with no expected entry, got code=%b insert=%b, expected an entry",
                             febe_code, febe_insert);
                end else begin
                    cur_exp = q_val.pop_front();
                    cur_req = q_req.pop_front();
                    check({febe_code, febe_insert}, cur_exp, cur_req);
                end
            end else begin
                check({febe_code, febe_insert}, cur_exp, "R5 R11 hold");
            end
        end
        pend = tx_mframe_start && rst_n;
    end

    // Advance to just after the next rising edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // k: 0 = F bit, 1 = M bit, 2 = CP parity
    task automatic err(input int k);
        if (k == 0) rx_fbit_err = 1'b1;
        else if (k == 1) rx_mbit_err = 1'b1;
        else rx_cp_err = 1'b1;
        cyc();
        rx_fbit_err = 1'b0;
        rx_mbit_err = 1'b0;
        rx_cp_err   = 1'b0;
        idle(2);
    endtask

    task automatic rx_end(input logic with_err);
        rx_mframe_end = 1'b1;
        rx_fbit_err   = with_err;
        cyc();
        rx_mframe_end = 1'b0;
        rx_fbit_err   = 1'b0;
        idle(2);
    endtask

    // Transmit frame start; optionally with a receive end (and error) at once.
    task automatic tx(input logic [3:0] exp, input string req,
                      input logic with_rx, input logic with_err);
        q_val.push_back(exp);
        q_req.push_back(req);
        tx_mframe_start = 1'b1;
        rx_mframe_end   = with_rx;
        rx_cp_err       = with_err;
        cyc();
        tx_mframe_start = 1'b0;
        rx_mframe_end   = 1'b0;
        rx_cp_err       = 1'b0;
        idle(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({febe_code, febe_insert}, E_OFF, "R1 reset");
        cyc();
        rst_n = 1'b1;
        idle(3);

        // R3: clean frame under automatic control
        rx_end(1'b0);
        tx(E_NULL, "R3 clean frame", 1'b0, 1'b0);

        // R2: each error source alone
        err(0); rx_end(1'b0); tx(E_ACT, "R2 F-bit error", 1'b0, 1'b0);
        err(1); rx_end(1'b0); tx(E_ACT, "R2 M-bit error", 1'b0, 1'b0);
        err(2); rx_end(1'b0); tx(E_ACT, "R2 CP parity error", 1'b0, 1'b0);
        rx_oof = 1'b1; idle(4); rx_oof = 1'b0; idle(2);
        rx_end(1'b0); tx(E_ACT, "R2 out of frame", 1'b0, 1'b0);

        // R4: error on the frame-end cycle, then the next frame is clean
        rx_end(1'b1); tx(E_ACT, "R4 error on end cycle", 1'b0, 1'b0);
        rx_end(1'b0); tx(E_NULL, "R4 accumulation cleared", 1'b0, 1'b0);
        // R4: error after the end belongs to the following frame
        rx_end(1'b0); err(2); tx(E_NULL, "R4 late error not in closed frame", 1'b0, 1'b0);
        rx_end(1'b0); tx(E_ACT, "R4 late error in next frame", 1'b0, 1'b0);

        // R6: receive end and transmit start together
        err(0); tx(E_ACT, "R6 coincident end, earlier error", 1'b1, 1'b0);
        tx(E_ACT, "R6 coincident end, error on that cycle", 1'b1, 1'b1);
        tx(E_NULL, "R6 coincident clean end over errored verdict", 1'b1, 1'b0);

        // R7: latest completed frame wins
        rx_end(1'b1); rx_end(1'b0); tx(E_NULL, "R7 errored then clean", 1'b0, 1'b0);
        rx_end(1'b0); rx_end(1'b1); tx(E_ACT, "R7 clean then errored", 1'b0, 1'b0);

        // R9: force bit ignored in automatic mode
        cfg_force_active = 1'b1;
        rx_end(1'b0); tx(E_NULL, "R9 force ignored, clean", 1'b0, 1'b0);
        cfg_force_active = 1'b0;
        rx_end(1'b1); tx(E_ACT, "R9 force ignored, errored", 1'b0, 1'b0);

        // R11: changing control mid-frame holds outputs until the boundary
        cfg_auto_defeat = 1'b1;
        idle(5);
        rx_end(1'b1);
        // R8: defeat with force 0 gives null despite errors
        tx(E_NULL, "R8 R11 defeat force 0 errored", 1'b0, 1'b0);
        cfg_force_active = 1'b1;
        idle(4);
        rx_end(1'b0);
        tx(E_ACT, "R8 defeat force 1 clean", 1'b0, 1'b0);

        // R10: E3 and M23 disable insertion whatever else is set
        cfg_e3_mode = 1'b1;
        rx_end(1'b1); tx(E_OFF, "R10 E3 mode", 1'b0, 1'b0);
        cfg_e3_mode = 1'b0; cfg_m23_fmt = 1'b1;
        rx_end(1'b1); tx(E_OFF, "R10 M23 format", 1'b0, 1'b0);
        cfg_auto_defeat = 1'b0;
        rx_end(1'b1); tx(E_OFF, "R10 M23 automatic errored", 1'b0, 1'b0);
        cfg_m23_fmt = 1'b0;
        rx_end(1'b1); tx(E_ACT, "R10 back to C-bit parity", 1'b0, 1'b0);

        idle(5);
        n_checks++;
        if (q_val.size() != 0) begin
            n_fail++;
            $display("FAIL R5: %0d frames not emitted, expected 0", q_val.size());
        end
        report();
    end

    // Watchdog
    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

endmodule